// File: doc/BRIEF.md
# Shared Code RAM Ownership Switch

This block owns a single 8 KB static RAM, organised as 4096 words of 16 bits, that holds the program of a secondary coprocessor core. At any moment exactly one side may use it. While the enable input is low, the coprocessor is held in reset and the RAM sits in the host core's data map. There the host can fill it through word or byte accesses. When the enable input goes high, the RAM leaves the host map and appears in the coprocessor's instruction space at 0x8000. The coprocessor reset is released in the same clock edge, so the first fetch it makes finds the RAM already in place.

The host loads the coprocessor program through the data port and then raises the enable input. To reload, it drops the enable input: the coprocessor falls back into reset one clock later and the RAM returns to the host map with its contents unchanged. Host reads and coprocessor fetches both return their data one clock after the request.

Top module: `code_ram_switch`

## Requirements
- R1: After reset, `coproRstN` is low and both `hostRdata` and `fetchData` read 0x0000.
- R2: With `hostByteMode` low and the enable registered low, host addresses 0x1000 to 0x1FFF reach RAM word (address − 0x1000). A write stores all 16 bits. A read returns the word on `hostRdata` in the cycle after the request.
- R3: With `hostByteMode` high, host addresses 0x1000 to 0x2FFF reach RAM word ((address − 0x1000) >> 1). Address bit 0 = 1 selects bits 15:8 and bit 0 = 0 selects bits 7:0. A byte write takes `hostWdata[7:0]` and leaves the other byte of the word unchanged. A byte read returns the selected byte zero-extended in bits 7:0.
- R4: Byte address 0x1000+2k+1 and byte address 0x1000+2k alias the upper and lower bytes of word address 0x1000+k.
- R5: The enable input is registered once. `coproRstN` goes high on the first clock edge at which the enable is sampled high, and the RAM passes to the coprocessor at that same edge.
- R6: While the coprocessor owns the RAM, host reads return 0x0000 and host writes leave the RAM unchanged.
- R7: While the coprocessor owns the RAM, a fetch from 0x8000 to 0x8FFF returns RAM word (address − 0x8000) on `fetchData` in the cycle after the request.
- R8: A fetch outside 0x8000 to 0x8FFF returns 0x0000 (the NOP encoding). Any fetch made while the coprocessor is in reset also returns 0x0000.
- R9: When the enable input falls, `coproRstN` goes low one clock later and the host regains the RAM with its contents intact.
- R10: Host accesses outside the active window return 0x0000 and do not modify the RAM. The word-mode window ends at 0x1FFF and the byte-mode window ends at 0x2FFF, so a word access at 0x2000 is outside its window.
- R11: In the cycle where the enable is first sampled high, a host write still lands, because ownership follows the registered state before that edge. A fetch issued in that same cycle returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Coprocessor enable; high hands the RAM to the coprocessor |
| hostReq | input | 1 | Host data access request |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostByteMode | input | 1 | Host byte addressing (1) or word addressing (0) |
| hostAddr | input | 16 | Host data address |
| hostWdata | input | 16 | Host write data; bits 7:0 used in byte mode |
| hostRdata | output | 16 | Host read data, valid the cycle after a read |
| fetchReq | input | 1 | Coprocessor instruction fetch request |
| fetchAddr | input | 16 | Coprocessor fetch address |
| fetchData | output | 16 | Fetched instruction word, valid the cycle after a fetch |
| coproRstN | output | 1 | Active-low coprocessor reset |

## Verification
An ownership change and a RAM access can happen in the same cycle. The enable rising edge may coincide with both a host write and a coprocessor fetch. The bench drives the enable, a host word write and a fetch together in one cycle. It then checks three things: the reset is released after that edge, the concurrent fetch returned the NOP value, and the host data reached the RAM. It confirms the last point by fetching the written word once the coprocessor owns the RAM. The reverse handover is checked by dropping the enable and reading the contents back through the host port.

// File: rtl/code_ram_pkg.sv
package code_ram_pkg;
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic rdHost;
    logic rdFetch;
    logic hiLane;
    logic byteMode;
  } ramStrobe_t;
endpackage

// File: rtl/code_ram_ctrl.sv
module code_ram_ctrl
  import code_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS = 4096,
  parameter logic [ADDR_W-1:0] HOST_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] FETCH_BASE = 16'h8000,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              hostByteMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output ramStrobe_t        strobe,
  output logic [IDX_W-1:0]  ramIdx,
  output logic              coproRstN
);
  localparam logic [ADDR_W:0] WORD_SPAN = (ADDR_W+1)'(WORDS);
  localparam logic [ADDR_W:0] BYTE_SPAN = (ADDR_W+1)'(2 * WORDS);

  logic coproOwns;
  logic pastValid;
  logic [ADDR_W:0] hostOff;
  logic [ADDR_W:0] fetchOff;
  logic inWordWin, inByteWin, inFetchWin, hostOk;
  logic [IDX_W-1:0] hostIdx, fetchIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coproOwns <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      coproOwns <= enable;
      pastValid <= 1'b1;
    end
  end

  assign coproRstN = coproOwns;

  always_comb begin
    hostOff    = {1'b0, hostAddr} - {1'b0, HOST_BASE};
    fetchOff   = {1'b0, fetchAddr} - {1'b0, FETCH_BASE};
    inWordWin  = (hostAddr >= HOST_BASE) && (hostOff < WORD_SPAN);
    inByteWin  = (hostAddr >= HOST_BASE) && (hostOff < BYTE_SPAN);
    inFetchWin = (fetchAddr >= FETCH_BASE) && (fetchOff < WORD_SPAN);
    hostIdx    = hostByteMode ? hostOff[IDX_W:1] : hostOff[IDX_W-1:0];
    fetchIdx   = fetchOff[IDX_W-1:0];
    hostOk     = !coproOwns && hostReq && (hostByteMode ? inByteWin : inWordWin);

    strobe.byteMode = hostByteMode;
    strobe.hiLane   = hostOff[0];
    strobe.wrLo     = hostOk && hostWe && (!hostByteMode || !hostOff[0]);
    strobe.wrHi     = hostOk && hostWe && (!hostByteMode || hostOff[0]);
    strobe.rdHost   = hostOk && !hostWe;
    strobe.rdFetch  = coproOwns && fetchReq && inFetchWin;
    ramIdx          = coproOwns ? fetchIdx : hostIdx;
  end

  AST_RST_TRACKS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (coproRstN == $past(enable))); // R5

  AST_RST_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !enable) |=> !coproRstN); // R9
endmodule

// File: rtl/code_ram_datapath.sv
module code_ram_datapath
  import code_ram_pkg::*;
#(
  parameter int WORDS = 4096,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [IDX_W-1:0]  ramIdx,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] fetchData
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdWord;
  logic rdHostQ, rdFetchQ, hiLaneQ, byteModeQ;
  logic [BYTE_W-1:0] hiWrByte;

  assign hiWrByte = strobe.byteMode ? hostWdata[BYTE_W-1:0] : hostWdata[DATA_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (strobe.wrLo) mem[ramIdx][BYTE_W-1:0] <= hostWdata[BYTE_W-1:0];
    if (strobe.wrHi) mem[ramIdx][DATA_W-1:BYTE_W] <= hiWrByte;
    rdWord <= mem[ramIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHostQ   <= 1'b0;
      rdFetchQ  <= 1'b0;
      hiLaneQ   <= 1'b0;
      byteModeQ <= 1'b0;
    end else begin
      rdHostQ   <= strobe.rdHost;
      rdFetchQ  <= strobe.rdFetch;
      hiLaneQ   <= strobe.hiLane;
      byteModeQ <= strobe.byteMode;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (rdHostQ) begin
      if (byteModeQ)
        hostRdata[BYTE_W-1:0] = hiLaneQ ? rdWord[DATA_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
      else
        hostRdata = rdWord;
    end
    fetchData = rdFetchQ ? rdWord : '0;
  end

  AST_BYTE_LANE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteMode |-> $onehot0({strobe.wrLo, strobe.wrHi})); // R3

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdFetch && (strobe.rdHost || strobe.wrLo || strobe.wrHi))); // R11
endmodule

// File: rtl/code_ram_switch.sv
module code_ram_switch
  import code_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WORDS = 4096,
  parameter logic [ADDR_W-1:0] HOST_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] FETCH_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              hostByteMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] fetchData,
  output logic              coproRstN
);
  localparam int IDX_W = $clog2(WORDS);

  ramStrobe_t strobe;
  logic [IDX_W-1:0] ramIdx;

  code_ram_ctrl #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .HOST_BASE(HOST_BASE), .FETCH_BASE(FETCH_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hostReq(hostReq), .hostWe(hostWe), .hostByteMode(hostByteMode), .hostAddr(hostAddr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .strobe(strobe), .ramIdx(ramIdx), .coproRstN(coproRstN)
  );

  code_ram_datapath #(
    .WORDS(WORDS), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramIdx(ramIdx),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .fetchData(fetchData)
  );

  AST_NO_HOST_WRITE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLo || strobe.wrHi) |-> !coproRstN); // R6

  AST_HOST_QUIET_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    coproRstN |=> (hostRdata == '0)); // R6

  AST_FETCH_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !coproRstN |=> (fetchData == '0)); // R8
endmodule

// File: tb/code_ram_switch_bench.sv
`timescale 1ns/1ps
module code_ram_switch_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0, hostByteMode = 1'b0;
  logic [15:0] hostAddr = '0, hostWdata = '0, fetchAddr = '0;
  logic fetchReq = 1'b0;
  logic [15:0] hostRdata, fetchData;
  logic coproRstN;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  code_ram_switch u_code_ram_switch (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hostReq(hostReq), .hostWe(hostWe), .hostByteMode(hostByteMode),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .coproRstN(coproRstN)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic bm, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b1; hostByteMode = bm; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic bm, input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b0; hostByteMode = bm; hostAddr = a;
    @(posedge clk); #1;
    d = hostRdata;
    hostReq = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a;
    @(posedge clk); #1;
    d = fetchData;
    fetchReq = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 coproRstN", {15'b0, coproRstN}, 16'h0);
    check("R1 hostRdata", hostRdata, 16'h0);
    check("R1 fetchData", fetchData, 16'h0);
    fetch(16'h8000, v);
    check("R8 fetch in reset", v, 16'h0);
  endtask

  task automatic t_word;
    logic [15:0] v;
    hostWrite(1'b0, 16'h1000, 16'hA5A5);
    hostWrite(1'b0, 16'h1FFF, 16'h1234);
    hostWrite(1'b0, 16'h1234, 16'hBEEF);
    hostRead(1'b0, 16'h1000, v); check("R2 word 0x1000", v, 16'hA5A5);
    hostRead(1'b0, 16'h1FFF, v); check("R2 word 0x1FFF", v, 16'h1234);
    hostRead(1'b0, 16'h1234, v); check("R2 word 0x1234", v, 16'hBEEF);
  endtask

  task automatic t_byte;
    logic [15:0] v;
    hostWrite(1'b1, 16'h2001, 16'hFF5A);
    hostWrite(1'b1, 16'h2000, 16'hFF3C);
    hostRead(1'b0, 16'h1800, v); check("R4 alias word 0x1800", v, 16'h5A3C);
    hostRead(1'b1, 16'h2001, v); check("R3 byte read odd", v, 16'h005A);
    hostRead(1'b1, 16'h2000, v); check("R3 byte read even", v, 16'h003C);
    hostWrite(1'b1, 16'h1001, 16'h0011);
    hostRead(1'b0, 16'h1000, v); check("R3 upper lane only", v, 16'h11A5);
    hostWrite(1'b1, 16'h2FFF, 16'h0077);
    hostRead(1'b0, 16'h1FFF, v); check("R10 byte window end", v, 16'h7734);
  endtask

  task automatic t_outside;
    logic [15:0] v;
    hostWrite(1'b0, 16'h2000, 16'hFFFF);
    hostWrite(1'b0, 16'h0FFF, 16'hFFFF);
    hostRead(1'b0, 16'h2000, v); check("R10 word read 0x2000", v, 16'h0);
    hostRead(1'b1, 16'h3000, v); check("R10 byte read 0x3000", v, 16'h0);
    hostRead(1'b0, 16'h1000, v); check("R10 word 0x1000 intact", v, 16'h11A5);
    hostRead(1'b0, 16'h1FFF, v); check("R10 word 0x1FFF intact", v, 16'h7734);
  endtask

  task automatic t_handover;
    logic [15:0] v;
    @(negedge clk);
    enable = 1'b1;
    hostReq = 1'b1; hostWe = 1'b1; hostByteMode = 1'b0; hostAddr = 16'h1100; hostWdata = 16'hCAFE;
    fetchReq = 1'b1; fetchAddr = 16'h8100;
    @(posedge clk); #1;
    hostReq = 1'b0; hostWe = 1'b0; fetchReq = 1'b0;
    check("R5 reset released", {15'b0, coproRstN}, 16'h1);
    check("R11 same-cycle fetch", fetchData, 16'h0);
    fetch(16'h8100, v); check("R11 same-cycle write landed", v, 16'hCAFE);
    fetch(16'h8000, v); check("R7 fetch 0x8000", v, 16'h11A5);
    fetch(16'h8FFF, v); check("R7 fetch 0x8FFF", v, 16'h7734);
    fetch(16'h9000, v); check("R8 fetch 0x9000", v, 16'h0);
    fetch(16'h7FFF, v); check("R8 fetch 0x7FFF", v, 16'h0);
  endtask

  task automatic t_owned;
    logic [15:0] v;
    hostRead(1'b0, 16'h1000, v); check("R6 host read owned", v, 16'h0);
    hostWrite(1'b0, 16'h1000, 16'h0000);
    hostWrite(1'b1, 16'h2001, 16'h0000);
    fetch(16'h8000, v); check("R6 host write ignored", v, 16'h11A5);
    fetch(16'h8800, v); check("R6 byte write ignored", v, 16'h5A3C);
  endtask

  task automatic t_release;
    logic [15:0] v;
    @(negedge clk);
    enable = 1'b0;
    @(posedge clk); #1;
    check("R9 reset asserted", {15'b0, coproRstN}, 16'h0);
    fetch(16'h8000, v); check("R8 fetch after release", v, 16'h0);
    hostRead(1'b0, 16'h1000, v); check("R9 contents intact", v, 16'h11A5);
    hostRead(1'b0, 16'h1100, v); check("R9 host regains", v, 16'hCAFE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_word();
    t_byte();
    t_outside();
    t_handover();
    t_owned();
    t_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule